// File: doc/BRIEF.md
# Round-Robin Bus Arbiter with Sequence-Triggered Lockout

This block shares one bus among four masters. On every clock edge it samples the request vector and loads a registered one-hot grant. Grants rotate in round-robin order, so the search for the next owner starts just after the master that was granted last. The block serves as a denial-of-service benchmark for hardware-trust studies.

A small state machine also watches the sampled request vectors for one rare, ordered series of single-master requests. The series is master 0, then master 3, then master 1, then master 2, on consecutive cycles. When the last vector of the series is sampled, a sticky lock is set. From then on no master is granted, whatever the requests are. Only a synchronous reset clears the lock. The `locked` output shows this state, so a bench or a monitor can see it.

Top module: `seq_lock_arbiter`

## Requirements
- R1: After a clock edge with `rst_n` low, `grant` is 0 and `locked` is 0. The round-robin pointer then gives master 0 the highest priority.
- R2: `grant` has at most one bit set. A set bit `grant[i]` only ever goes to a master whose `req[i]` was high in the vector sampled at the previous edge.
- R3: The grant is registered. It reflects the requests sampled at the previous edge. While the block is unlocked, any nonzero sampled request vector gives a nonzero grant.
- R4: Round-robin order: the master granted is the first requester found at or after the one following the last granted master, wrapping from 3 to 0. A cycle with no requests leaves the pointer unchanged.
- R5: The block locks when four consecutively sampled request vectors are 4'b0001, 4'b1000, 4'b0010 and 4'b0100, in that order, where bit i is master i. `locked` rises at the edge that samples the fourth vector.
- R6: A vector that breaks a partial match restarts the matching. If that vector equals 4'b0001, it counts as the first element of a new match.
- R7: While `locked` is high, `grant` is all zeros for every request pattern. This includes the edge that samples the fourth trigger vector.
- R8: Once set, `locked` stays high through any requests, including a repeat of the trigger series. Only an edge with `rst_n` low clears it, and normal arbitration then resumes.
- R9: A prefix of the series that is followed by any other vector does not lock the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 4 | Request vector, bit i from master i |
| grant | output | 4 | Registered one-hot grant |
| locked | output | 1 | High once the trigger series has been seen |

## Verification
The lockout is the state that is hardest to reach from the ports. Random traffic almost never produces four exact single-master vectors on consecutive cycles. The stimulus therefore drives the series on purpose. It also drives prefixes cut off at each length, and an overlapping case in which a repeated 4'b0001 must restart the match rather than be dropped. Ordinary arbitration is swept over every pair of request vectors and over random traffic. The bench checks each cycle against an arithmetic pointer model.

// File: rtl/seqlock_pkg.sv
// Package: shared constants and helpers for the sequence-lock arbiter.
// Assumes the master count does not exceed 32.
package seqlock_pkg;

    // Length of the ordered trigger series.
    localparam int TRIG_LEN = 4;

    // Master index requested alone at step k of the trigger series.
    function automatic int trig_master(input int k);
        case (k)
            0:       return 0;
            1:       return 3;
            2:       return 1;
            default: return 2;
        endcase
    endfunction

    // One-hot request vector expected at step k for a bus of n masters.
    function automatic logic [31:0] trig_vec(input int k, input int n);
        return 32'(1) << (trig_master(k) % n);
    endfunction

endpackage

// File: rtl/rr_picker.sv
// Module: rr_picker
// Combinational round-robin search. It scans the requests starting one
// position after ptr, wraps around, and returns the first requester as
// a one-hot vector and as an index.
// Assumes N >= 2 and that ptr < N.
module rr_picker #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic [N-1:0]  pick,
    output logic [IW-1:0] pick_idx,
    output logic          pick_any
);

    // Scan the requests in rotated order and keep the first hit.
    always_comb begin
        pick     = '0;
        pick_idx = '0;
        pick_any = 1'b0;
        for (int off = 1; off <= N; off++) begin
            int c;
            c = (int'(ptr) + off) % N;
            if (!pick_any && req[c]) begin
                pick[c]  = 1'b1;
                pick_idx = IW'(c);
                pick_any = 1'b1;
            end
        end
    end

endmodule

// File: rtl/seq_watch.sv
// Module: seq_watch
// Watches the sampled request vectors for the ordered trigger series.
// hit pulses for one cycle when the last vector of the series arrives
// right after the earlier ones. A mismatching vector restarts the match,
// and it is also tested as the first element of a new match.
// Assumes the trigger elements are distinct, so a restart can only go
// back to element zero.
module seq_watch #(
    parameter int N   = 4,
    parameter int LEN = seqlock_pkg::TRIG_LEN,
    localparam int CW = $clog2(LEN + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic         hit
);

    logic [N-1:0]  pat [LEN];
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;
    logic [N-1:0]  expect_v;

    // Build the expected vector for each step from the package table.
    for (genvar k = 0; k < LEN; k++) begin : g_pat
        localparam logic [31:0] PV = seqlock_pkg::trig_vec(k, N);
        assign pat[k] = PV[N-1:0];
    end

    // Select the vector expected at the current match depth.
    always_comb begin
        expect_v = pat[0];
        for (int k = 0; k < LEN; k++) begin
            if (cnt_q == CW'(k)) expect_v = pat[k];
        end
    end

    // Advance, finish or restart the match.
    always_comb begin
        hit   = 1'b0;
        cnt_d = '0;
        if (req == expect_v) begin
            if (cnt_q == CW'(LEN - 1)) begin
                hit   = 1'b1;
                cnt_d = '0;
            end else begin
                cnt_d = cnt_q + CW'(1);
            end
        end else if (req == pat[0]) begin
            cnt_d = CW'(1);
        end
    end

    // Match-depth register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/lock_latch.sv
// Module: lock_latch
// Sticky lock flag. The set input takes effect at the next edge, and only
// a synchronous reset clears the flag.
module lock_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    output logic locked
);

    // Set-only register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)   locked <= 1'b0;
        else if (set) locked <= 1'b1;
    end

endmodule

// File: rtl/seq_lock_arbiter.sv
// Module: seq_lock_arbiter (top)
// Round-robin arbiter with a registered one-hot grant. A seq_watch
// instance looks for the trigger series in the requests, and lock_latch
// holds the resulting lockout. While locked, or at the edge that
// completes the series, the grant register loads zero. The pointer
// records the last granted master and moves only when a grant is made.
// Assumes N >= 2.
module seq_lock_arbiter #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         locked
);

    logic [IW-1:0] ptr_q;
    logic [N-1:0]  pick;
    logic [IW-1:0] pick_idx;
    logic          pick_any;
    logic          hit;
    logic          block_grant;

    rr_picker #(.N(N)) u_pick (
        .req      (req),
        .ptr      (ptr_q),
        .pick     (pick),
        .pick_idx (pick_idx),
        .pick_any (pick_any)
    );

    seq_watch #(.N(N), .LEN(seqlock_pkg::TRIG_LEN)) u_watch (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .hit   (hit)
    );

    lock_latch u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (hit),
        .locked (locked)
    );

    // Suppress grants once locked or as the lock is being taken.
    assign block_grant = locked | hit;

    // Grant register and round-robin pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant <= '0;
            ptr_q <= IW'(N - 1);
        end else begin
            grant <= block_grant ? '0 : pick;
            if (!block_grant && pick_any) ptr_q <= pick_idx;
        end
    end

endmodule

// File: rtl/seqlock_arb_checker.sv
// Module: seqlock_arb_checker
// Port-level properties of seq_lock_arbiter, attached with bind.
module seqlock_arb_checker #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] req,
    input logic [N-1:0] grant,
    input logic         locked
);

    localparam logic [31:0] LASTV =
        seqlock_pkg::trig_vec(seqlock_pkg::TRIG_LEN - 1, N);

    assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_grant_to_requester_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |-> ((grant & $past(req)) == grant));

    assert_work_conserving_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && $past(rst_n) && (|$past(req))) |-> (|grant));

    assert_lock_on_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> ($past(req) == LASTV[N-1:0]));

    assert_no_grant_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (grant == '0));

    assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

endmodule

bind seq_lock_arbiter seqlock_arb_checker #(.N(N)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (req),
    .grant  (grant),
    .locked (locked)
);

// File: tb/seq_lock_arbiter_tb.sv
module seq_lock_arbiter_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req = '0;
    logic [3:0] grant;
    logic       locked;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Reference model state
    int       m_ptr;
    int       m_cnt;
    bit       m_lock;
    logic [3:0] exp_grant;
    logic [3:0] SEQ [4] = '{4'b0001, 4'b1000, 4'b0010, 4'b0100};
    int       gcount [4];

    seq_lock_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .grant(grant), .locked(locked)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req   = '0;
        @(posedge clk);
        #1;
        m_ptr = 3; m_cnt = 0; m_lock = 0;
        check(grant == 4'b0000, "R1 grant after reset", grant, 4'b0000);
        check(locked == 1'b0, "R1 locked after reset", {3'b0, locked}, 4'b0000);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive one vector, advance the model at the edge, compare after it.
    task automatic step(input logic [3:0] v, input string tag);
        bit hit;
        @(negedge clk);
        req = v;
        @(posedge clk);
        #1;
        hit = 0;
        if (v == SEQ[m_cnt]) begin
            if (m_cnt == 3) begin hit = 1; m_cnt = 0; end
            else m_cnt++;
        end else begin
            m_cnt = (v == SEQ[0]) ? 1 : 0;
        end
        exp_grant = '0;
        if (!m_lock && !hit) begin
            for (int off = 1; off <= 4; off++) begin
                int c;
                c = (m_ptr + off) % 4;
                if (exp_grant == '0 && v[c]) begin
                    exp_grant[c] = 1'b1;
                    m_ptr = c;
                end
            end
        end
        if (hit) m_lock = 1;
        for (int i = 0; i < 4; i++) if (grant[i]) gcount[i]++;
        check(grant == exp_grant, {tag, " grant"}, grant, exp_grant);
        check(locked == m_lock, {tag, " locked"}, {3'b0, locked}, {3'b0, m_lock});
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        // R1: reset state, then master 0 first
        do_reset();
        step(4'b1111, "R1 first priority");
        check(grant == 4'b0001, "R1 master0 first", grant, 4'b0001);

        // R2 R3 R4: every pair of request vectors
        do_reset();
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++) begin
                step(4'(a), "R4 sweep");
                step(4'(b), "R2 R3 sweep");
            end

        // R4: fairness under full load
        do_reset();
        for (int i = 0; i < 4; i++) gcount[i] = 0;
        for (int k = 0; k < 8; k++) step(4'b1111, "R4 full load");
        for (int i = 0; i < 4; i++)
            check(gcount[i] == 2, "R4 fair share", 4'(gcount[i]), 4'd2);

        // R4 R2: random traffic
        do_reset();
        for (int k = 0; k < 3000; k++) step(4'($urandom_range(0, 15)), "R4 random");

        // R9: each prefix cut off by another vector
        for (int cut = 1; cut <= 3; cut++) begin
            do_reset();
            for (int k = 0; k < cut; k++) step(SEQ[k], "R9 prefix");
            step(4'b0000, "R9 broken");
            check(locked == 1'b0, "R9 no lock after prefix", {3'b0, locked}, 4'b0000);
        end
        do_reset();
        step(4'b0001, "R9"); step(4'b1000, "R9"); step(4'b0010, "R9"); step(4'b0110, "R9");
        check(locked == 1'b0, "R9 near miss", {3'b0, locked}, 4'b0000);

        // R6: restart with a repeated first element
        do_reset();
        step(4'b0001, "R6"); step(4'b1000, "R6"); step(4'b0001, "R6 restart");
        step(4'b1000, "R6"); step(4'b0010, "R6"); step(4'b0100, "R6 final");
        check(locked == 1'b1, "R6 lock after restart", {3'b0, locked}, 4'b0001);

        // R5 R7: clean series, grant zero at the completing edge
        do_reset();
        step(4'b0001, "R5"); step(4'b1000, "R5"); step(4'b0010, "R5");
        step(4'b0100, "R5 final");
        check(locked == 1'b1, "R5 locked", {3'b0, locked}, 4'b0001);
        check(grant == 4'b0000, "R7 no grant at trigger", grant, 4'b0000);

        // R7 R8: all requests while locked, then series again
        for (int v = 0; v < 16; v++) step(4'(v), "R7 locked sweep");
        for (int k = 0; k < 4; k++) step(SEQ[k], "R8 repeat series");
        for (int k = 0; k < 20; k++) step(4'b1111, "R8 still locked");
        check(locked == 1'b1, "R8 sticky", {3'b0, locked}, 4'b0001);

        // R8: reset recovers
        do_reset();
        step(4'b0100, "R8 recovered");
        check(grant == 4'b0100, "R8 grant after reset", grant, 4'b0100);
        step(4'b1111, "R8 recovered rr");
        check(grant == 4'b1000, "R8 rr after reset", grant, 4'b1000);

        finish_run();
    end

endmodule